// File: doc/BRIEF.md
# Palette Loader and Color Expander

This block fills a palette RAM for one display channel. A start strobe with the load flag set makes it take in a stream of 32-bit raw palette words and keep them in an internal buffer. It then turns each word into a common entry: 8 bits each of red, green and blue, plus a transparency flag. The finished entries go out on a write port, one per cycle, followed by a one-cycle done pulse. How many entries there are depends on the pixel depth code. The layout of each raw word is chosen by a 2-bit format field, and a monochrome flag makes every entry grey.

A start strobe with the load flag clear asks for a reparse. If the current format field differs from the format last used, the block expands the buffered raw words again under the new format. It fetches no new words for this. If the format is the same, the strobe does nothing. Pixel lookup and drawing belong to other blocks.

Top module: `palette_loader`

## Requirements
- R1: The depth code selects the number of entries: code 1 gives 4, code 2 gives 16 and code 3 gives 256. The entries are written to addresses 0 up to that count minus 1, in ascending order, and entry k is built from the k-th raw word taken in.
- R2: A start strobe is ignored when the depth code is 0, 4, 5, 6 or 7. No words are taken in, no entry is written, no done pulse is given, and the buffered words and their count stay as they were.
- R3: Each written entry carries transparency in bit 24, red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Format 0 reads red from word bits 15:11, green from 10:5 and blue from 4:0, and forces transparency to 0. Each narrow component is shifted to the top of its 8 bits, with zeros in the low bits.
- R4: Format 1 uses the same colour fields as format 0, and transparency comes from word bit 24.
- R5: Format 2 reads red from word bits 23:19, green from 15:10 and blue from 7:3, each placed at the top of its 8 bits with zeros below, and transparency comes from word bit 24.
- R6: Format 3 reads red from word bits 23:16, green from 15:8 and blue from 7:0, and transparency comes from word bit 24.
- R7: With the monochrome flag set, red, green and blue all equal word bits 7:0, whatever the format. Transparency still follows the format.
- R8: A start with the load flag clear, a valid depth code and a format different from the last one used re-expands the buffered words under the new format. It writes the same number of entries as the last load and takes in no words.
- R9: A start with the load flag clear and a format equal to the last one used writes nothing and gives no done pulse.
- R10: Entries of one job are written on consecutive cycles. Done is high for exactly one cycle, the cycle after the last entry is written.
- R11: A start strobe that arrives while a load or expansion is in progress, up to and including the done cycle, is ignored.
- R12: After reset, the write strobe and done are low, and a reparse request writes nothing until a load has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle job request |
| load_i | input | 1 | With start_i: 1 means load new words, 0 means reparse check |
| depth_i | input | 3 | Pixel depth code |
| fmt_i | input | 2 | Raw word format |
| mono_i | input | 1 | Grey output mode |
| word_valid_i | input | 1 | A raw word is present on word_i |
| word_i | input | 32 | Raw palette word |
| pal_we_o | output | 1 | Palette RAM write strobe |
| pal_addr_o | output | 8 | Palette RAM write address |
| pal_data_o | output | 25 | Expanded entry {transparency, red, green, blue} |
| done_o | output | 1 | One-cycle pulse after the last entry |

## Verification
The hardest case to reach from the ports is a reparse that has to rebuild a full 256-entry palette from words buffered many jobs earlier. It has to do this after ignored starts with bad depth codes and after strobes sent while the block was busy. The bench keeps its own copy of every word it streams in, along with the count and format of the last accepted job. It then asks for reparses under a new format, under the same format, and with monochrome set, and checks every entry against its own copy. Starts during a load are placed in gaps of the word stream, so an ignored strobe cannot hide behind a consumed word.

// File: rtl/pal_pkg.sv
// Shared constants, types and helpers for the palette loader.
// Assumes an 8-bit palette address (256 entries at most).
package pal_pkg;
    localparam int PAL_IDX_W   = 8;
    localparam int PAL_CNT_W   = PAL_IDX_W + 1;
    localparam int PAL_ENTRY_W = 25;
    localparam int PAL_DEPTH_W = 3;
    localparam int PAL_FMT_W   = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_PARSE = 2'd2,
        ST_DRAIN = 2'd3
    } seq_state_t;

    // Entry count for a depth code; zero means the code is not palettised.
    function automatic logic [PAL_CNT_W-1:0] depth_count(input logic [PAL_DEPTH_W-1:0] code);
        logic [PAL_CNT_W-1:0] n;
        case (code)
            3'd1:    n = PAL_CNT_W'(4);
            3'd2:    n = PAL_CNT_W'(16);
            3'd3:    n = PAL_CNT_W'(1) << PAL_IDX_W;
            default: n = '0;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/pal_raw_buf.sv
// Raw palette word store: one write port, one registered read port.
// Assumes the read data is wanted one cycle after the address is presented.
module pal_raw_buf #(
    parameter int WORD_W = 32,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] mem [DEPTH];

    // Store incoming words and read back one word per cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/pal_expand.sv
// Combinational conversion of one raw word into a {t, r, g, b} entry.
// Assumes WORD_W is at least 25 so the transparency bit exists.
module pal_expand
    import pal_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0]      word,
    input  logic [PAL_FMT_W-1:0]   fmt,
    input  logic                   mono,
    output logic [PAL_ENTRY_W-1:0] entry
);
    localparam int TBIT = 24;

    logic [7:0] r, g, b;
    logic       t;

    // Pick fields by format, then override colour for grey mode.
    always_comb begin
        t = word[TBIT];
        case (fmt)
            2'd0: begin
                r = {word[15:11], 3'b000};
                g = {word[10:5], 2'b00};
                b = {word[4:0], 3'b000};
                t = 1'b0;
            end
            2'd1: begin
                r = {word[15:11], 3'b000};
                g = {word[10:5], 2'b00};
                b = {word[4:0], 3'b000};
            end
            2'd2: begin
                r = {word[23:19], 3'b000};
                g = {word[15:10], 2'b00};
                b = {word[7:3], 3'b000};
            end
            default: begin
                r = word[23:16];
                g = word[15:8];
                b = word[7:0];
            end
        endcase
        if (mono) begin
            r = word[7:0];
            g = word[7:0];
            b = word[7:0];
        end
        entry = {t, r, g, b};
    end
endmodule

// File: rtl/pal_seq.sv
// Job sequencer: accepts load or reparse requests, steers raw words into
// the buffer and issues one buffer read per cycle during expansion.
// Assumes done_in arrives some cycles after the last read; the sequencer
// stays busy until it sees it.
module pal_seq
    import pal_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   load,
    input  logic [PAL_DEPTH_W-1:0] depth,
    input  logic [PAL_FMT_W-1:0]   fmt,
    input  logic                   mono,
    input  logic                   word_valid,
    input  logic                   done_in,
    output logic                   buf_we,
    output logic [PAL_IDX_W-1:0]   buf_waddr,
    output logic                   rd_fire,
    output logic [PAL_IDX_W-1:0]   rd_addr,
    output logic                   rd_last,
    output logic [PAL_FMT_W-1:0]   used_fmt,
    output logic                   used_mono
);
    seq_state_t             state;
    logic [PAL_IDX_W-1:0]   idx;
    logic [PAL_IDX_W-1:0]   last_idx;
    logic                   have_data;
    logic [PAL_CNT_W-1:0]   req_cnt;
    logic [PAL_CNT_W-1:0]   req_cnt_m1;
    logic                   req_ok;

    // Decode the requested depth into a count and its last index.
    always_comb begin
        req_cnt    = depth_count(depth);
        req_ok     = (req_cnt != '0);
        req_cnt_m1 = req_cnt - PAL_CNT_W'(1);
    end

    // Buffer write and read strobes follow the current phase.
    always_comb begin
        buf_we    = (state == ST_LOAD) && word_valid;
        buf_waddr = idx;
        rd_fire   = (state == ST_PARSE);
        rd_addr   = idx;
        rd_last   = (state == ST_PARSE) && (idx == last_idx);
    end

    // Phase sequencing, index counting and capture of the job settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            idx       <= '0;
            last_idx  <= '0;
            have_data <= 1'b0;
            used_fmt  <= '0;
            used_mono <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start && req_ok) begin
                        if (load) begin
                            state     <= ST_LOAD;
                            idx       <= '0;
                            last_idx  <= req_cnt_m1[PAL_IDX_W-1:0];
                            have_data <= 1'b0;
                            used_fmt  <= fmt;
                            used_mono <= mono;
                        end else if (have_data && (fmt != used_fmt)) begin
                            state     <= ST_PARSE;
                            idx       <= '0;
                            used_fmt  <= fmt;
                            used_mono <= mono;
                        end
                    end
                end
                ST_LOAD: begin
                    if (word_valid) begin
                        if (idx == last_idx) begin
                            state     <= ST_PARSE;
                            idx       <= '0;
                            have_data <= 1'b1;
                        end else begin
                            idx <= idx + PAL_IDX_W'(1);
                        end
                    end
                end
                ST_PARSE: begin
                    if (idx == last_idx) begin
                        state <= ST_DRAIN;
                    end else begin
                        idx <= idx + PAL_IDX_W'(1);
                    end
                end
                default: begin
                    if (done_in) begin
                        state <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // R10: reads of one expansion are issued back to back.
    p_reads_contiguous_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && !rd_last) |=> rd_fire);

    // R11: settings of a running job do not move.
    p_settings_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && $past(rd_fire)) |-> ($stable(used_fmt) && $stable(used_mono)));
endmodule

// File: rtl/palette_loader.sv
// Palette loader top: buffers raw palette words, expands them to
// {transparency, r, g, b} entries and writes them out one per cycle.
// Assumes the palette RAM accepts a write on every cycle pal_we_o is high.
module palette_loader
    import pal_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   load_i,
    input  logic [PAL_DEPTH_W-1:0] depth_i,
    input  logic [PAL_FMT_W-1:0]   fmt_i,
    input  logic                   mono_i,
    input  logic                   word_valid_i,
    input  logic [WORD_W-1:0]      word_i,
    output logic                   pal_we_o,
    output logic [PAL_IDX_W-1:0]   pal_addr_o,
    output logic [PAL_ENTRY_W-1:0] pal_data_o,
    output logic                   done_o
);
    logic                   buf_we;
    logic [PAL_IDX_W-1:0]   buf_waddr;
    logic                   rd_fire;
    logic [PAL_IDX_W-1:0]   rd_addr;
    logic                   rd_last;
    logic [PAL_FMT_W-1:0]   used_fmt;
    logic                   used_mono;
    logic [WORD_W-1:0]      raw_q;
    logic [PAL_ENTRY_W-1:0] entry;
    logic                   rd_v_q;
    logic [PAL_IDX_W-1:0]   rd_addr_q;
    logic                   rd_last_q;
    logic                   wr_last_q;

    pal_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_i),
        .load       (load_i),
        .depth      (depth_i),
        .fmt        (fmt_i),
        .mono       (mono_i),
        .word_valid (word_valid_i),
        .done_in    (done_o),
        .buf_we     (buf_we),
        .buf_waddr  (buf_waddr),
        .rd_fire    (rd_fire),
        .rd_addr    (rd_addr),
        .rd_last    (rd_last),
        .used_fmt   (used_fmt),
        .used_mono  (used_mono)
    );

    pal_raw_buf #(.WORD_W(WORD_W), .AW(PAL_IDX_W)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (word_i),
        .raddr (rd_addr),
        .rdata (raw_q)
    );

    pal_expand #(.WORD_W(WORD_W)) u_exp (
        .word  (raw_q),
        .fmt   (used_fmt),
        .mono  (used_mono),
        .entry (entry)
    );

    // Align read tags with the buffer output, then register the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_v_q     <= 1'b0;
            rd_addr_q  <= '0;
            rd_last_q  <= 1'b0;
            pal_we_o   <= 1'b0;
            pal_addr_o <= '0;
            pal_data_o <= '0;
            wr_last_q  <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            rd_v_q     <= rd_fire;
            rd_addr_q  <= rd_addr;
            rd_last_q  <= rd_last;
            pal_we_o   <= rd_v_q;
            pal_addr_o <= rd_addr_q;
            pal_data_o <= entry;
            wr_last_q  <= rd_v_q && rd_last_q;
            done_o     <= pal_we_o && wr_last_q;
        end
    end

    // R1: addresses of consecutive writes step by one.
    p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pal_we_o && $past(pal_we_o)) |-> (pal_addr_o == $past(pal_addr_o) + PAL_IDX_W'(1)));

    // R10: done only follows a write cycle.
    p_done_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(pal_we_o));

    // R10: no gap before the final entry.
    p_writes_contiguous_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pal_we_o && !wr_last_q) |=> pal_we_o);

    // R3: format 0 entries are never transparent.
    p_fmt0_opaque_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pal_we_o && used_fmt == 2'd0) |-> !pal_data_o[24]);

    // R7: grey mode gives equal components.
    p_mono_grey_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pal_we_o && used_mono) |->
        (pal_data_o[23:16] == pal_data_o[15:8] && pal_data_o[15:8] == pal_data_o[7:0]));
endmodule

// File: tb/palette_loader_test.sv
module palette_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        load_i = 1'b0;
    logic [2:0]  depth_i = '0;
    logic [1:0]  fmt_i = '0;
    logic        mono_i = 1'b0;
    logic        word_valid_i = 1'b0;
    logic [31:0] word_i = '0;
    logic        pal_we_o;
    logic [7:0]  pal_addr_o;
    logic [24:0] pal_data_o;
    logic        done_o;

    palette_loader uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .load_i(load_i),
        .depth_i(depth_i), .fmt_i(fmt_i), .mono_i(mono_i),
        .word_valid_i(word_valid_i), .word_i(word_i),
        .pal_we_o(pal_we_o), .pal_addr_o(pal_addr_o),
        .pal_data_o(pal_data_o), .done_o(done_o)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int cycles = 0;
    string cur_tag = "R1";

    logic [7:0]  exp_addr_q [$];
    logic [24:0] exp_data_q [$];
    logic [31:0] mbuf [256];
    int          mcount = 0;

    logic        prev_we = 1'b0;
    logic [7:0]  prev_addr = '0;
    int          job_last = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [24:0] model(input logic [31:0] w, input logic [1:0] f, input bit m);
        logic [7:0] r, g, b;
        logic t;
        t = (f == 2'd0) ? 1'b0 : w[24];
        if (f[1] == 1'b0) begin
            r = {w[15:11], 3'b0}; g = {w[10:5], 2'b0}; b = {w[4:0], 3'b0};
        end else if (f == 2'd2) begin
            r = {w[23:19], 3'b0}; g = {w[15:10], 2'b0}; b = {w[7:3], 3'b0};
        end else begin
            r = w[23:16]; g = w[15:8]; b = w[7:0];
        end
        if (m) begin
            r = w[7:0]; g = w[7:0]; b = w[7:0];
        end
        return {t, r, g, b};
    endfunction

    function automatic int cnt_of(input logic [2:0] d);
        return (d == 3'd1) ? 4 : (d == 3'd2) ? 16 : (d == 3'd3) ? 256 : 0;
    endfunction

    // Scoreboard monitor: compare each write and check done placement.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (pal_we_o) begin
                if (exp_addr_q.size() == 0) begin
                    chk(1'b0, cur_tag, "unexpected write addr", pal_addr_o, 0);
                end else begin
                    logic [7:0]  ea;
                    logic [24:0] ed;
                    ea = exp_addr_q.pop_front();
                    ed = exp_data_q.pop_front();
                    chk(pal_addr_o == ea, cur_tag, "write addr", pal_addr_o, ea);
                    chk(pal_data_o == ed, cur_tag, "write data", pal_data_o, ed);
                end
            end else if (prev_we && prev_addr != job_last[7:0]) begin
                chk(1'b0, "R10", "write gap before last entry", prev_addr, job_last);
            end
            if (done_o) begin
                done_cnt++;
                chk(prev_we && prev_addr == job_last[7:0], "R10",
                    "done not right after last write", prev_addr, job_last);
                chk(exp_addr_q.size() == 0, "R10", "done with entries pending",
                    exp_addr_q.size(), 0);
            end
            prev_we   = pal_we_o;
            prev_addr = pal_addr_o;
        end
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        wait (cycles > 150000);
        chk(1'b0, "WD", "watchdog expired", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic expect_job(input logic [1:0] f, input bit m);
        for (int i = 0; i < mcount; i++) begin
            exp_addr_q.push_back(8'(i));
            exp_data_q.push_back(model(mbuf[i], f, m));
        end
        job_last = mcount - 1;
    endtask

    task automatic wait_done(input string tag);
        int start_cnt = done_cnt;
        int guard = 0;
        while (done_cnt == start_cnt && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk(done_cnt == start_cnt + 1, tag, "done count", done_cnt, start_cnt + 1);
        @(negedge clk);
    endtask

    task automatic pulse_start(input bit ld, input logic [2:0] d, input logic [1:0] f, input bit m);
        load_i = ld; depth_i = d; fmt_i = f; mono_i = m; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Driver: stream words, optionally with gaps and a stray start in a gap.
    task automatic do_load(input logic [2:0] d, input logic [1:0] f, input bit m,
                           input logic [31:0] seed, input bit gaps, input string tag);
        cur_tag = tag;
        mcount = cnt_of(d);
        for (int i = 0; i < mcount; i++) mbuf[i] = (32'(i) * 32'h9E3779B1) ^ seed;
        expect_job(f, m);
        pulse_start(1'b1, d, f, m);
        for (int i = 0; i < mcount; i++) begin
            if (gaps && (i % 3 == 1)) begin
                word_valid_i = 1'b0;
                if (i == 7) begin
                    start_i = 1'b1; load_i = 1'b1; depth_i = 3'd1;  // R11: stray start mid-load
                end
                @(negedge clk);
                start_i = 1'b0; depth_i = d;
            end
            word_valid_i = 1'b1; word_i = mbuf[i];
            @(negedge clk);
        end
        word_valid_i = 1'b0;
        wait_done(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(pal_we_o == 1'b0, "R12", "write strobe in reset", pal_we_o, 0);
        chk(done_o == 1'b0, "R12", "done in reset", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reparse before any load writes nothing
        pulse_start(1'b0, 3'd1, 2'd3, 1'b0);
        repeat (12) @(negedge clk);
        chk(done_cnt == 0, "R12", "done after reparse with empty buffer", done_cnt, 0);

        do_load(3'd1, 2'd0, 1'b0, 32'h0155_AA0F, 1'b0, "R3");
        do_load(3'd2, 2'd1, 1'b0, 32'h0A0B_0C0D, 1'b0, "R4");
        do_load(3'd3, 2'd2, 1'b0, 32'h5A5A_1234, 1'b1, "R5");
        chk(mcount == 256, "R1", "entries for depth code 3", mcount, 256);

        // R8 and R6: reparse into format 3; a stray start during it is ignored (R11)
        cur_tag = "R6";
        expect_job(2'd3, 1'b0);
        pulse_start(1'b0, 3'd3, 2'd3, 1'b0);
        repeat (20) @(negedge clk);
        pulse_start(1'b0, 3'd3, 2'd1, 1'b0);
        wait_done("R8");
        repeat (12) @(negedge clk);
        chk(exp_addr_q.size() == 0 && done_cnt == 4, "R11", "start during expansion",
            done_cnt, 4);

        // R9: same format gives nothing
        cur_tag = "R9";
        pulse_start(1'b0, 3'd3, 2'd3, 1'b1);
        repeat (12) @(negedge clk);
        chk(done_cnt == 4, "R9", "done after same-format reparse", done_cnt, 4);

        // R7: grey over format 0 via reparse, then grey load with format 1
        cur_tag = "R7";
        expect_job(2'd0, 1'b1);
        pulse_start(1'b0, 3'd3, 2'd0, 1'b1);
        wait_done("R7");
        do_load(3'd1, 2'd1, 1'b1, 32'h0F0F_F0F0, 1'b0, "R7");

        // R2: bad depth codes ignored, buffer and count untouched
        cur_tag = "R2";
        pulse_start(1'b1, 3'd0, 2'd2, 1'b0);
        for (int i = 0; i < 4; i++) begin
            word_valid_i = 1'b1; word_i = 32'hDEAD_BEEF;
            @(negedge clk);
        end
        word_valid_i = 1'b0;
        pulse_start(1'b0, 3'd5, 2'd2, 1'b0);
        repeat (12) @(negedge clk);
        chk(done_cnt == 6, "R2", "done after invalid depth", done_cnt, 6);
        expect_job(2'd2, 1'b0);
        pulse_start(1'b0, 3'd2, 2'd2, 1'b0);
        wait_done("R2");
        chk(job_last == 3, "R1", "entry count kept from 2 bpp load", job_last + 1, 4);

        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule